// File: doc/BRIEF.md
# Time-Multiplexed MAC FIR Filter Engine

This block is a filter accelerator built around a single signed 24x24 multiply-accumulate unit. The unit is shared over time: one filter tap is multiplied and added per clock, so an N-tap output takes N busy cycles. The block holds 64 coefficient entries and 64 sample entries. They can work as one 64-tap direct-form filter, or as four independent 16-tap channels, each with its own delay line and its own coefficient bank.

A DMA engine or a processor drives a simple register-style port with a write strobe, a read strobe, an address and write data. Read data comes back combinationally in the same cycle. Writing a sample to a channel pushes it into that channel's delay line and schedules a computation. When the result is ready, the channel's request line goes high. Reading the result lowers it again. In partitioned mode, samples that arrive while another channel is computing wait in a queue, and the queue is served in round-robin order.

Address map (7-bit address): 0x00-0x3F write coefficient entry `addr`. 0x40+c writes a sample to channel c, and reading 0x40+c returns channel c's last result. 0x48 is control on write (bit 0 = partitioned mode, bit 1 = clear delay lines) and status on read (bit 0 = partitioned mode, bit 1 = busy). Every other address reads as zero and ignores writes.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `dma_req` is all zero, status (0x48) reads 0, every result address reads 0, and all delay-line entries and coefficients are zero.
- R2: In single mode (status bit 0 = 0), a sample written to 0x40 produces the result y = rs(sum over k=0..63 of coef[k] * x[n-k]), where x[n] is the newest sample and older entries start at zero.
- R3: The output rounding is rs(a) = (a + 2^22) >>> 23, so exact halves round toward plus infinity (acc 2^22 gives 1, -2^22 gives 0, 3*2^22 gives 2, -3*2^22 gives -1).
- R4: A rounded value above 8388607 is returned as 0x7FFFFF, and one below -8388608 is returned as 0x800000.
- R5: In partitioned mode (bit 0 = 1), channel c computes rs(sum over k=0..15 of coef[16c+k] * x_c[n-k]) using only its own delay line.
- R6: When the engine is idle, `dma_req[c]` rises exactly len+1 clock edges after the edge that accepts the sample (65 in single mode, 17 in partitioned mode). Status bit 1 (busy) is 1 while a computation is queued or running.
- R7: Reading address 0x40+c lowers `dma_req[c]` at that edge, unless a new result for c completes in the same cycle.
- R8: A coefficient write while status busy is 1 is ignored, and later results use the earlier coefficient.
- R9: In partitioned mode, a sample for another channel is accepted while one channel computes. Queued channels start in round-robin order after the last one served (ch2 serving, then ch1, ch3, ch0 queued gives result order 2, 3, 0, 1).
- R10: Writing control with bit 1 set while idle zeros every delay line and leaves coefficients unchanged.
- R11: A sample is ignored (no shift, no computation) when it is written to channel c while c is computing, to any channel while busy in single mode, or to channels 1-3 in single mode.
- R12: A control write while busy is ignored. A control write that changes bit 0 zeros all delay lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (result reads clear the request) |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Combinational read data |
| dma_req | output | 4 | Per-channel result-ready request |

## Verification
The bench goes after rounding at exact half values. A design that truncates or rounds half away from zero returns 0 instead of 1 for 2^22, or -2 instead of -1 for -3*2^22. It drives full-scale sums past both limits, where a design without saturation wraps the sign. It writes a burst of samples during a partitioned computation: a wrong arbiter shows up as the wrong request order, and a design that accepts a duplicate sample for the running channel returns a result computed with an extra shift. It also writes coefficients and control while busy, and clears the delay lines, so any write that leaks through shows up as a changed later result or status.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int unsigned DATA_W    = 24;
  localparam int unsigned ACC_W     = 54;
  localparam int unsigned FRAC_W    = 23;
  localparam int unsigned DEPTH     = 64;
  localparam int unsigned NCH       = 4;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned SAMP_BASE = 64;
  localparam int unsigned CTRL_ADDR = 72;

  localparam int unsigned CTRL_PART_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT  = 1;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_COEF,
    ACC_SAMP,
    ACC_CTRL
  } acc_kind_e;
endpackage

// File: rtl/fir_bus_dec.sv
module fir_bus_dec
  import fir_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NC    = NCH,
  parameter int unsigned TAPS  = DEPTH,
  localparam int unsigned CH_W = $clog2(NC)
) (
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   addr,
  output acc_kind_e       kind,
  output logic [CH_W-1:0] ch,
  output logic            coef_wr,
  output logic            ctrl_wr,
  output logic [NC-1:0]   samp_wr,
  output logic [NC-1:0]   res_rd
);
  localparam logic [AW-1:0] A_COEF_END = AW'(TAPS);
  localparam logic [AW-1:0] A_SAMP     = AW'(SAMP_BASE);
  localparam logic [AW-1:0] A_SAMP_END = AW'(SAMP_BASE + NC);
  localparam logic [AW-1:0] A_CTRL     = AW'(CTRL_ADDR);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - A_SAMP;
    ch  = off[CH_W-1:0];
    if (addr < A_COEF_END)                         kind = ACC_COEF;
    else if (addr >= A_SAMP && addr < A_SAMP_END)  kind = ACC_SAMP;
    else if (addr == A_CTRL)                       kind = ACC_CTRL;
    else                                           kind = ACC_NONE;
  end

  always_comb begin
    samp_wr = '0;
    res_rd  = '0;
    if (kind == ACC_SAMP) begin
      samp_wr[ch] = bus_wr;
      res_rd[ch]  = bus_rd;
    end
  end

  assign coef_wr = bus_wr && (kind == ACC_COEF);
  assign ctrl_wr = bus_wr && (kind == ACC_CTRL);
endmodule

// File: rtl/fir_store.sv
module fir_store
  import fir_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned TAPS   = DEPTH,
  parameter int unsigned NC     = NCH,
  localparam int unsigned IDX_W = $clog2(TAPS),
  localparam int unsigned CH_W  = $clog2(NC),
  localparam int unsigned SEG_W = IDX_W - CH_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 part,
  input  logic                 clr,
  input  logic                 coef_we,
  input  logic [IDX_W-1:0]     coef_idx,
  input  logic [DW-1:0]        coef_din,
  input  logic                 samp_we,
  input  logic [CH_W-1:0]      samp_ch,
  input  logic [DW-1:0]        samp_din,
  input  logic [CH_W-1:0]      rd_ch,
  input  logic [IDX_W-1:0]     rd_tap,
  output logic signed [DW-1:0] rd_x,
  output logic signed [DW-1:0] rd_c
);
  logic [DW-1:0]    cmem [TAPS];
  logic [DW-1:0]    smem [TAPS];
  logic [IDX_W-1:0] head [NC];
  logic [IDX_W-1:0] new_head;
  logic [IDX_W-1:0] wr_slot;

  // Map a channel-relative position to a physical entry; partitioned mode
  // keeps each channel inside its own segment, single mode spans the array.
  function automatic logic [IDX_W-1:0] slot(input logic p, input logic [CH_W-1:0] c,
                                            input logic [IDX_W-1:0] pos);
    if (p) slot = {c, pos[SEG_W-1:0]};
    else   slot = pos;
  endfunction

  assign new_head = head[samp_ch] - 1'b1;
  assign wr_slot  = slot(part, samp_ch, new_head);
  assign rd_x     = $signed(smem[slot(part, rd_ch, head[rd_ch] + rd_tap)]);
  assign rd_c     = $signed(cmem[slot(part, rd_ch, rd_tap)]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(TAPS); i++) cmem[i] <= '0;
    end else if (coef_we) begin
      cmem[coef_idx] <= coef_din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < int'(TAPS); i++) smem[i] <= '0;
      for (int c = 0; c < int'(NC); c++)   head[c] <= '0;
    end else if (samp_we) begin
      smem[wr_slot]  <= samp_din;
      head[samp_ch]  <= new_head;
    end
  end
endmodule

// File: rtl/fir_rr_sched.sv
module fir_rr_sched
  import fir_pkg::*;
#(
  parameter int unsigned NC    = NCH,
  localparam int unsigned CH_W = $clog2(NC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NC-1:0]   set_vec,
  input  logic            take,
  output logic [NC-1:0]   pend,
  output logic            grant_vld,
  output logic [CH_W-1:0] grant_ch
);
  logic [CH_W-1:0] last;
  logic [NC-1:0]   take_mask;

  always_comb begin
    grant_vld = 1'b0;
    grant_ch  = '0;
    for (int off = 1; off <= int'(NC); off++) begin
      logic [CH_W-1:0] idx;
      idx = CH_W'((int'(last) + off) % int'(NC));
      if (!grant_vld && pend[idx]) begin
        grant_vld = 1'b1;
        grant_ch  = idx;
      end
    end
  end

  assign take_mask = take ? (NC'(1) << grant_ch) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pend <= '0;
      last <= CH_W'(NC - 1);
    end else begin
      pend <= (pend & ~take_mask) | set_vec;
      if (take) last <= grant_ch;
    end
  end
endmodule

// File: rtl/fir_mac_core.sv
module fir_mac_core
  import fir_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned AW_ACC = ACC_W,
  parameter int unsigned FW     = FRAC_W,
  parameter int unsigned TAPS   = DEPTH,
  parameter int unsigned NC     = NCH,
  localparam int unsigned IDX_W = $clog2(TAPS),
  localparam int unsigned CH_W  = $clog2(NC),
  localparam int unsigned PW    = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CH_W-1:0]      start_ch,
  input  logic [IDX_W-1:0]     len_m1,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] c,
  output logic                 busy,
  output logic [CH_W-1:0]      cur_ch,
  output logic [IDX_W-1:0]     tap,
  output logic                 done,
  output logic [DW-1:0]        result
);
  localparam logic signed [AW_ACC:0] HALF = (AW_ACC + 1)'(1) << (FW - 1);
  localparam logic signed [AW_ACC:0] OMAX = (AW_ACC + 1)'((64'sd1 << (DW - 1)) - 1);
  localparam logic signed [AW_ACC:0] OMIN = -OMAX - 1;

  logic signed [AW_ACC-1:0] acc;
  logic signed [AW_ACC-1:0] acc_nx;
  logic signed [PW-1:0]     prod;

  // Round half toward +inf, drop the fraction, clamp to the output range.
  function automatic logic [DW-1:0] round_sat(input logic signed [AW_ACC-1:0] a);
    logic signed [AW_ACC:0] r;
    r = ($signed({a[AW_ACC-1], a}) + HALF) >>> FW;
    if (r > OMAX)      round_sat = OMAX[DW-1:0];
    else if (r < OMIN) round_sat = OMIN[DW-1:0];
    else               round_sat = r[DW-1:0];
  endfunction

  assign prod   = x * c;
  assign acc_nx = acc + $signed({{(AW_ACC - PW){prod[PW-1]}}, prod});
  assign done   = busy && (tap == len_m1);
  assign result = round_sat(acc_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tap    <= '0;
      acc    <= '0;
      cur_ch <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      tap    <= '0;
      acc    <= '0;
      cur_ch <= start_ch;
    end else if (busy) begin
      acc <= acc_nx;
      tap <= tap + 1'b1;
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned AW_ACC = ACC_W,
  parameter int unsigned FW     = FRAC_W,
  parameter int unsigned TAPS   = DEPTH,
  parameter int unsigned NC     = NCH,
  parameter int unsigned AW     = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NC-1:0] dma_req
);
  localparam int unsigned IDX_W = $clog2(TAPS);
  localparam int unsigned CH_W  = $clog2(NC);
  localparam int unsigned SEG   = TAPS / NC;

  acc_kind_e       kind;
  logic [CH_W-1:0] bus_ch;
  logic            coef_wr, ctrl_wr, coef_accept, ctrl_accept, clr_lines;
  logic [NC-1:0]   samp_wr, samp_accept, res_rd, pend;
  logic            mode_q, busy, done, start, grant_vld, eng_busy;
  logic [CH_W-1:0] cur_ch, start_ch;
  logic [IDX_W-1:0] tap, len_m1;
  logic signed [DW-1:0] tap_x, tap_c;
  logic [DW-1:0]   mac_result;
  logic [DW-1:0]   res_q [NC];
  logic [NC-1:0]   req_q;

  fir_bus_dec #(.AW(AW), .NC(NC), .TAPS(TAPS)) u_dec (
    .bus_wr (bus_wr), .bus_rd (bus_rd), .addr (bus_addr), .kind (kind), .ch (bus_ch),
    .coef_wr (coef_wr), .ctrl_wr (ctrl_wr), .samp_wr (samp_wr), .res_rd (res_rd)
  );

  assign eng_busy    = busy || (|pend);
  assign coef_accept = coef_wr && !eng_busy;
  assign ctrl_accept = ctrl_wr && !eng_busy;
  assign clr_lines   = ctrl_accept &&
                       (bus_wdata[CTRL_CLR_BIT] || (bus_wdata[CTRL_PART_BIT] != mode_q));

  generate
    for (genvar g = 0; g < int'(NC); g++) begin : g_accept
      if (g == 0) begin : g_ch0
        assign samp_accept[g] = samp_wr[g] &&
                                (mode_q ? !(busy && cur_ch == CH_W'(g)) : !eng_busy);
      end else begin : g_chn
        assign samp_accept[g] = samp_wr[g] && mode_q && !(busy && cur_ch == CH_W'(g));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= 1'b0;
    else if (ctrl_accept) mode_q <= bus_wdata[CTRL_PART_BIT];
  end

  fir_store #(.DW(DW), .TAPS(TAPS), .NC(NC)) u_store (
    .clk (clk), .rst_n (rst_n), .part (mode_q), .clr (clr_lines),
    .coef_we (coef_accept), .coef_idx (bus_addr[IDX_W-1:0]), .coef_din (bus_wdata),
    .samp_we (|samp_accept), .samp_ch (bus_ch), .samp_din (bus_wdata),
    .rd_ch (cur_ch), .rd_tap (tap), .rd_x (tap_x), .rd_c (tap_c)
  );

  fir_rr_sched #(.NC(NC)) u_sched (
    .clk (clk), .rst_n (rst_n), .clr (clr_lines), .set_vec (samp_accept),
    .take (start), .pend (pend), .grant_vld (grant_vld), .grant_ch (start_ch)
  );

  assign start  = grant_vld && !busy;
  assign len_m1 = mode_q ? IDX_W'(SEG - 1) : IDX_W'(TAPS - 1);

  fir_mac_core #(.DW(DW), .AW_ACC(AW_ACC), .FW(FW), .TAPS(TAPS), .NC(NC)) u_mac (
    .clk (clk), .rst_n (rst_n), .start (start), .start_ch (start_ch), .len_m1 (len_m1),
    .x (tap_x), .c (tap_c), .busy (busy), .cur_ch (cur_ch), .tap (tap),
    .done (done), .result (mac_result)
  );

  generate
    for (genvar g = 0; g < int'(NC); g++) begin : g_res
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_q[g] <= '0;
          req_q[g] <= 1'b0;
        end else if (done && cur_ch == CH_W'(g)) begin
          res_q[g] <= mac_result;
          req_q[g] <= 1'b1;
        end else if (res_rd[g]) begin
          req_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (kind)
      ACC_SAMP: bus_rdata = res_q[bus_ch];
      ACC_CTRL: bus_rdata = {{(DW - 2){1'b0}}, eng_busy, mode_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign dma_req = req_q;
endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int unsigned TAPS   = 64,
  parameter int unsigned NC     = 4,
  localparam int unsigned IDX_W = $clog2(TAPS),
  localparam int unsigned CH_W  = $clog2(NC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_q,
  input logic            busy,
  input logic            eng_busy,
  input logic            done,
  input logic            start,
  input logic            coef_accept,
  input logic [CH_W-1:0] cur_ch,
  input logic [CH_W-1:0] start_ch,
  input logic [NC-1:0]   samp_wr,
  input logic [NC-1:0]   samp_accept,
  input logic [NC-1:0]   res_rd,
  input logic [NC-1:0]   dma_req
);
  logic [NC-1:0]  done_mask;
  logic [IDX_W:0] run_cnt;
  logic [IDX_W:0] exp_last;

  assign done_mask = done ? (NC'(1) << cur_ch) : '0;
  assign exp_last  = mode_q ? (IDX_W + 1)'(TAPS / NC - 1) : (IDX_W + 1)'(TAPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || start) run_cnt <= '0;
    else if (busy)       run_cnt <= run_cnt + 1'b1;
  end

  // R6: a finished computation raises its channel request
  p_req_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((dma_req & $past(done_mask)) == $past(done_mask)));

  // R6: every computation runs exactly the tap count of its mode
  p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == exp_last));

  // R8: coefficients change only while nothing is queued or running
  p_coef_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coef_accept |-> (!busy && !start));

  // R2: single mode only ever schedules channel 0
  p_single_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode_q) |-> (start_ch == '0));

  // R9: a new computation never starts over a running one
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R11: single mode accepts nothing while the engine is occupied
  p_single_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && eng_busy) |-> (samp_accept == '0));

  generate
    for (genvar g = 0; g < int'(NC); g++) begin : g_ch
      // R7: reading a result lowers its request unless a new one lands
      p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd[g] && !done_mask[g]) |=> !dma_req[g]);
      // R11: the running channel refuses its own new sample
      p_self_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_wr[g] && busy && cur_ch == CH_W'(g)) |-> !samp_accept[g]);
    end
  endgenerate
endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS), .NC(NC)) u_chk (
  .clk (clk), .rst_n (rst_n), .mode_q (mode_q), .busy (busy), .eng_busy (eng_busy),
  .done (done), .start (start), .coef_accept (coef_accept), .cur_ch (cur_ch),
  .start_ch (start_ch), .samp_wr (samp_wr), .samp_accept (samp_accept),
  .res_rd (res_rd), .dma_req (dma_req)
);

// File: tb/fir_mac_engine_tb.sv
module fir_mac_engine_tb;
  localparam int A_SAMP = 64;
  localparam int A_CTRL = 72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic [3:0]  dma_req;

  int n_chk = 0;
  int n_fail = 0;
  int mc [64];
  int hist [4][64];
  bit part_m = 1'b0;

  always #10 clk = ~clk;

  fir_mac_engine u_dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .dma_req (dma_req)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = 24'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 7'(a);
    #1 d = int'($signed(bus_rdata));
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_req(input int ch, output int n);
    n = 0;
    while (!dma_req[ch] && n < 1000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  function automatic void clear_hist();
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 64; k++) hist[c][k] = 0;
  endfunction

  function automatic void push(input int ch, input int x);
    for (int k = 63; k > 0; k--) hist[ch][k] = hist[ch][k-1];
    hist[ch][0] = x;
  endfunction

  function automatic int expect_ch(input int ch);
    longint s = 0;
    longint q;
    int n = part_m ? 16 : 64;
    int base = part_m ? 16 * ch : 0;
    for (int k = 0; k < n; k++) s += longint'(mc[base + k]) * longint'(hist[ch][k]);
    q = (s + (64'sd1 <<< 22)) >>> 23;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return int'(q);
  endfunction

  task automatic load_coefs();
    for (int k = 0; k < 64; k++) bus_write(k, mc[k]);
  endtask

  // write a sample, wait for its request, read and compare against the model
  task automatic run_sample(input int ch, input int x, input string tag, output int got);
    int n;
    bus_write(A_SAMP + ch, x);
    push(ch, x);
    wait_req(ch, n);
    bus_read(A_SAMP + ch, got);
    check(got == expect_ch(ch), tag, got, expect_ch(ch));
  endtask

  task automatic t_reset();
    int d;
    check(dma_req == 4'h0, "R1 dma_req after reset", dma_req, 0);
    bus_read(A_CTRL, d);
    check(d == 0, "R1 status after reset", d, 0);
    bus_read(A_SAMP + 2, d);
    check(d == 0, "R1 result after reset", d, 0);
  endtask

  task automatic t_single();
    int n, d;
    for (int k = 0; k < 64; k++) mc[k] = ((k * 7919) % 4001 - 2000) * 1000;
    load_coefs();
    bus_write(A_SAMP, 1234567); push(0, 1234567);
    wait_req(0, n);
    check(n == 65, "R6 single-mode latency", n, 65);
    bus_read(A_SAMP, d);
    check(d == expect_ch(0), "R2 first single result", d, expect_ch(0));
    #1 check(dma_req[0] == 1'b0, "R7 request cleared by read", dma_req[0], 0);
    run_sample(0, -2345678, "R2 second single result", d);
    run_sample(0, 777, "R2 third single result", d);
  endtask

  task automatic t_coef_busy();
    int n, d;
    bus_write(A_SAMP, 3000000); push(0, 3000000);
    bus_read(A_CTRL, d);
    check(d == 2, "R6 busy status during compute", d, 2);
    bus_write(5, 4000000);  // must be dropped
    wait_req(0, n);
    bus_read(A_SAMP, d);
    check(d == expect_ch(0), "R8 result during ignored coef write", d, expect_ch(0));
    bus_write(10, 0);       // still busy? no: idle now, so restore a defined value below
    mc[10] = 0;
    run_sample(0, -5000000, "R8 coef unchanged after busy write", d);
  endtask

  task automatic t_single_drop();
    int n, d;
    bus_write(A_SAMP + 1, 999);
    repeat (80) @(posedge clk);
    #1 check(dma_req == 4'h0, "R11 channel 1 ignored in single mode", dma_req, 0);
    bus_read(A_CTRL, d);
    check(d == 0, "R11 no computation for channel 1", d, 0);
    bus_write(A_SAMP, 4444444); push(0, 4444444);
    bus_write(A_SAMP, -4444444);  // queued engine: dropped
    wait_req(0, n);
    bus_read(A_SAMP, d);
    check(d == expect_ch(0), "R11 second sample while busy ignored", d, expect_ch(0));
    repeat (70) @(posedge clk);
    #1 check(dma_req == 4'h0, "R11 dropped sample started nothing", dma_req, 0);
  endtask

  task automatic t_round();
    int d;
    for (int k = 0; k < 64; k++) mc[k] = 0;
    mc[0] = 4194304;
    load_coefs();
    bus_write(A_CTRL, 2); clear_hist();
    run_sample(0, 1, "R3 model +half", d);
    check(d == 1, "R3 +half rounds up", d, 1);
    run_sample(0, -1, "R3 model -half", d);
    check(d == 0, "R3 -half rounds to zero", d, 0);
    run_sample(0, 3, "R3 model 1.5", d);
    check(d == 2, "R3 1.5 rounds to 2", d, 2);
    run_sample(0, -3, "R3 model -1.5", d);
    check(d == -1, "R3 -1.5 rounds to -1", d, -1);
  endtask

  task automatic t_sat();
    int d;
    for (int k = 0; k < 64; k++) mc[k] = 8388607;
    load_coefs();
    bus_write(A_CTRL, 2); clear_hist();
    run_sample(0, 8388607, "R4 one full-scale product", d);
    run_sample(0, 8388607, "R4 model positive", d);
    check(d == 8388607, "R4 positive saturation", d, 8388607);
    for (int i = 0; i < 4; i++) run_sample(0, -8388608, "R4 model negative", d);
    check(d == -8388608, "R4 negative saturation", d, -8388608);
  endtask

  task automatic t_clear();
    int d;
    bus_write(A_CTRL, 2); clear_hist();
    run_sample(0, 5, "R10 cleared lines keep coefs", d);
    check(d == 5, "R10 result after clear", d, 5);
  endtask

  task automatic t_partition();
    int d, n;
    int order [4];
    int exp_order [4] = '{2, 3, 0, 1};
    logic [3:0] seen;
    bus_write(A_CTRL, 1); clear_hist(); part_m = 1'b1;
    bus_read(A_CTRL, d);
    check(d == 1, "R12 partitioned mode bit", d, 1);
    for (int k = 0; k < 64; k++) mc[k] = ((k / 16) + 1) * 300000 - (k % 16) * 17000;
    load_coefs();
    bus_write(A_SAMP + 2, 2000000); push(2, 2000000);
    bus_write(A_SAMP + 1, -1500000); push(1, -1500000);
    bus_write(A_SAMP + 3, 3100000); push(3, 3100000);
    bus_write(A_SAMP + 0, 4100000); push(0, 4100000);
    bus_write(A_SAMP + 2, -7000000);  // channel 2 running: dropped
    seen = '0; n = 0;
    for (int cyc = 0; cyc < 200 && n < 4; cyc++) begin
      for (int c = 0; c < 4; c++)
        if (dma_req[c] && !seen[c]) begin seen[c] = 1'b1; order[n] = c; n++; end
      @(posedge clk); #1;
    end
    check(n == 4, "R9 all queued channels served", n, 4);
    for (int i = 0; i < 4; i++)
      check(order[i] == exp_order[i], "R9 round-robin order", order[i], exp_order[i]);
    for (int c = 0; c < 4; c++) begin
      bus_read(A_SAMP + c, d);
      check(d == expect_ch(c), "R5 independent channel result", d, expect_ch(c));
    end
    bus_write(A_SAMP + 1, 250000); push(1, 250000);
    bus_write(A_CTRL, 0);  // busy: ignored
    wait_req(1, n);
    bus_read(A_CTRL, d);
    check(d == 1, "R12 control write while busy ignored", d, 1);
    bus_read(A_SAMP + 1, d);
    check(d == expect_ch(1), "R5 second channel-1 result", d, expect_ch(1));
    bus_write(A_CTRL, 0); clear_hist(); part_m = 1'b0;
    run_sample(0, 6000000, "R12 mode change clears delay lines", d);
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_hist();
    for (int k = 0; k < 64; k++) mc[k] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_single();
    t_coef_busy();
    t_single_drop();
    t_round();
    t_sat();
    t_clear();
    t_partition();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule